// File: doc/BRIEF.md
# Hall Commutation Mode Selector

This block sits between the debounced hall sensor logic of a three-phase brushless motor drive and the waveform generator that follows it. It turns the three hall levels into a rotor sector index. It checks that successive hall codes step in the direction that the forward/reverse select asks for. It flags the two hall codes that can never occur on a healthy sensor. It also derives two speed tachometer pulses: one pulse per electrical cycle and three pulses per electrical cycle.

From the triple-rate pulse the block measures rotor speed as a count of clock ticks between rising edges. A motor always starts in 120-degree block commutation. The block grants 180-degree sinusoidal drive only when the rotor is fast enough and two rising edges of hall phase 2 have arrived in the commanded direction. It withdraws that grant at once on a wrong-way step, on loss of speed, or in power-save.

Top module: `hall_mode_sel`

## Requirements
- R1: While reset is held and in the cycle after it, `mode_sine` is 0, `outputs_off` is 0 and `sector` is 0.
- R2: A valid hall code {H1,H2,H3} = `hall_in[2:0]` maps to `sector` as 101→0, 100→1, 110→2, 010→3, 011→4, 001→5; `sector` follows the input two clock edges after it is applied.
- R3: Hall codes 000 and 111 set `outputs_off` to 1 two edges after they are applied, and `sector` keeps the last valid value; a valid code clears `outputs_off`.
- R4: `fg1` equals H1 and `fg3` equals H1^H2^H3, one edge after the input, so `fg3` gives three pulses per electrical cycle and `fg1` one.
- R5: While `pwr_save` is 1, `fg1` and `fg3` are 1, and `mode_sine` is 0 from the next edge on.
- R6: `mode_sine` becomes 1 once the speed flag is set and two rising edges of H2 have occurred on correct-direction steps while it was set.
- R7: With `dir_rev` = 1 the expected order is the forward order reversed (sector decreasing by one modulo 6), and R6 applies to that order.
- R8: A valid step that is not the expected neighbour for the commanded direction clears `mode_sine` and the edge count at the next edge, even when that step raises H2.
- R9: The speed flag is set when the time between rising edges of `fg3` is at most `PERIOD_MAX` cycles and cleared once `PERIOD_MAX` cycles pass without one; while it is clear `mode_sine` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hall_in | input | 3 | Debounced hall levels {H1,H2,H3} |
| dir_rev | input | 1 | Commanded direction, 0 forward, 1 reverse |
| pwr_save | input | 1 | Power-save request |
| mode_sine | output | 1 | 1 = 180-degree drive, 0 = 120-degree drive |
| outputs_off | output | 1 | Invalid hall code seen, drive must be off |
| sector | output | 3 | Rotor sector index 0..5 |
| fg1 | output | 1 | Speed pulse, one per electrical cycle |
| fg3 | output | 1 | Speed pulse, three per electrical cycle |

## Verification
A wrong-way step and a rising edge of H2 can land in the same cycle: stepping from 001 back to 011 under a forward command raises H2 while breaking the order. The bench first brings the rotor to sinusoidal drive at speed, then makes exactly that step, and expects `mode_sine` at 0 and the sector at 4. The same collision is repeated in reverse, where a forward step is the violation. Power-save arriving while sinusoidal drive is granted is judged on both the tachometer outputs and the mode flag.

// File: rtl/hall_mode_pkg.sv
package hall_mode_pkg;

    localparam logic [2:0] SEC_NONE  = 3'd7;
    localparam logic [2:0] HOME_CODE = 3'b101;

    typedef enum logic { MODE_BLOCK = 1'b0, MODE_SINE = 1'b1 } drive_mode_e;

    // Rotor sector from a hall code {H1,H2,H3}; SEC_NONE for 000 and 111.
    function automatic logic [2:0] hall_to_sec(input logic [2:0] code);
        case (code)
            3'b101:  return 3'd0;
            3'b100:  return 3'd1;
            3'b110:  return 3'd2;
            3'b010:  return 3'd3;
            3'b011:  return 3'd4;
            3'b001:  return 3'd5;
            default: return SEC_NONE;
        endcase
    endfunction

    // Sector expected after one step in the commanded direction.
    function automatic logic [2:0] sec_next(input logic [2:0] sec, input logic rev);
        if (rev) return (sec == 3'd0) ? 3'd5 : sec - 3'd1;
        else     return (sec == 3'd5) ? 3'd0 : sec + 3'd1;
    endfunction

endpackage

// File: rtl/hall_seq_check.sv
module hall_seq_check
    import hall_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_q,
    input  logic       dir_rev,
    output logic [2:0] sector,
    output logic       outputs_off,
    output logic       mismatch,
    output logic       h2_rise
);
    logic [2:0] code_r;
    logic       have_ref;
    logic       off_r;
    logic [2:0] sec_now;
    logic [2:0] sec_ref;
    logic       change;

    always_comb begin
        sec_now  = hall_to_sec(hall_q);
        sec_ref  = hall_to_sec(code_r);
        change   = (sec_now != SEC_NONE) && have_ref && (sec_now != sec_ref);
        mismatch = change && (sec_now != sec_next(sec_ref, dir_rev));
        h2_rise  = change && !mismatch && hall_q[1] && !code_r[1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_r   <= HOME_CODE;
            have_ref <= 1'b0;
            off_r    <= 1'b0;
        end else begin
            off_r <= (sec_now == SEC_NONE);
            if (sec_now != SEC_NONE) begin
                code_r   <= hall_q;
                have_ref <= 1'b1;
            end
        end
    end

    assign sector      = sec_ref;
    assign outputs_off = off_r;

endmodule

// File: rtl/fg_speed.sv
module fg_speed #(
    parameter int PERIOD_MAX = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_q,
    input  logic       pwr_save,
    output logic       fg1,
    output logic       fg3,
    output logic       fast
);
    localparam int TW = $clog2(PERIOD_MAX + 1);
    localparam logic [TW-1:0] LIMIT = TW'(PERIOD_MAX);

    logic          par;
    logic          par_d;
    logic [TW-1:0] tcnt;

    assign par = ^hall_q;
    assign fg1 = pwr_save | hall_q[2];
    assign fg3 = pwr_save | par;

    always_ff @(posedge clk) begin
        if (rst) begin
            par_d <= 1'b0;
            tcnt  <= '0;
            fast  <= 1'b0;
        end else begin
            par_d <= par;
            if (par && !par_d) begin
                fast <= (tcnt < LIMIT);
                tcnt <= '0;
            end else if (tcnt == LIMIT) begin
                fast <= 1'b0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mode_arbiter.sv
module mode_arbiter
    import hall_mode_pkg::*;
#(
    parameter int EDGE_NEED = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_save,
    input  logic fast,
    input  logic mismatch,
    input  logic h2_rise,
    output logic mode_sine
);
    localparam int CW = $clog2(EDGE_NEED + 1);
    localparam logic [CW-1:0] LAST = CW'(EDGE_NEED - 1);

    logic [CW-1:0] cnt;
    drive_mode_e   mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            mode <= MODE_BLOCK;
        end else if (pwr_save || mismatch || !fast) begin
            cnt  <= '0;
            mode <= MODE_BLOCK;
        end else if (h2_rise) begin
            if (cnt >= LAST) mode <= MODE_SINE;
            else             cnt  <= cnt + 1'b1;
        end
    end

    assign mode_sine = (mode == MODE_SINE);

endmodule

// File: rtl/hall_mode_sel.sv
module hall_mode_sel
    import hall_mode_pkg::*;
#(
    parameter int PERIOD_MAX = 100,
    parameter int EDGE_NEED  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir_rev,
    input  logic       pwr_save,
    output logic       mode_sine,
    output logic       outputs_off,
    output logic [2:0] sector,
    output logic       fg1,
    output logic       fg3
);
    logic [2:0] hall_q;
    logic       fast;
    logic       mismatch;
    logic       h2_rise;

    always_ff @(posedge clk) begin
        if (rst) hall_q <= HOME_CODE;
        else     hall_q <= hall_in;
    end

    hall_seq_check u_seq (
        .clk(clk), .rst(rst), .hall_q(hall_q), .dir_rev(dir_rev),
        .sector(sector), .outputs_off(outputs_off),
        .mismatch(mismatch), .h2_rise(h2_rise)
    );

    fg_speed #(.PERIOD_MAX(PERIOD_MAX)) u_spd (
        .clk(clk), .rst(rst), .hall_q(hall_q), .pwr_save(pwr_save),
        .fg1(fg1), .fg3(fg3), .fast(fast)
    );

    mode_arbiter #(.EDGE_NEED(EDGE_NEED)) u_arb (
        .clk(clk), .rst(rst), .pwr_save(pwr_save), .fast(fast),
        .mismatch(mismatch), .h2_rise(h2_rise), .mode_sine(mode_sine)
    );

endmodule

// File: rtl/hall_mode_chk.sv
module hall_mode_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_save,
    input logic       mode_sine,
    input logic       fast,
    input logic       mismatch,
    input logic       fg1,
    input logic       fg3,
    input logic [2:0] sector,
    input logic       outputs_off,
    input logic [2:0] hall_q
);
    a_r2_sector_range: assert property (@(posedge clk) disable iff (rst)
        sector < 3'd6);

    a_r3_off_on_invalid: assert property (@(posedge clk) disable iff (rst)
        (hall_q == 3'b000 || hall_q == 3'b111) |=> outputs_off);

    a_r3_sector_held: assert property (@(posedge clk) disable iff (rst)
        (hall_q == 3'b000 || hall_q == 3'b111) |=> $stable(sector));

    a_r5_fg_high: assert property (@(posedge clk) disable iff (rst)
        pwr_save |-> (fg1 && fg3));

    a_r5_mode_drop: assert property (@(posedge clk) disable iff (rst)
        pwr_save |=> !mode_sine);

    a_r6_needs_speed: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_sine) |-> $past(fast));

    a_r8_mismatch_drop: assert property (@(posedge clk) disable iff (rst)
        mismatch |=> !mode_sine);

    a_r9_slow_drop: assert property (@(posedge clk) disable iff (rst)
        !fast |=> !mode_sine);

endmodule

bind hall_mode_sel hall_mode_chk u_chk (
    .clk(clk), .rst(rst), .pwr_save(pwr_save), .mode_sine(mode_sine),
    .fast(fast), .mismatch(mismatch), .fg1(fg1), .fg3(fg3),
    .sector(sector), .outputs_off(outputs_off), .hall_q(hall_q)
);

// File: tb/sim_hall_mode_sel.sv
module sim_hall_mode_sel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] hall_in = 3'b101;
    logic       dir_rev = 1'b0;
    logic       pwr_save = 1'b0;
    logic       mode_sine, outputs_off, fg1, fg3;
    logic [2:0] sector;

    int checks = 0;
    int fails  = 0;
    int pos    = 0;

    always #5 clk = ~clk;

    hall_mode_sel u0 (
        .clk(clk), .rst(rst), .hall_in(hall_in), .dir_rev(dir_rev),
        .pwr_save(pwr_save), .mode_sine(mode_sine), .outputs_off(outputs_off),
        .sector(sector), .fg1(fg1), .fg3(fg3)
    );

    // forward hall order {H1,H2,H3} by sector
    localparam logic [2:0] FWD [6] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001};

    // vector: hall, expected sector, off, fg1, fg3
    typedef struct packed {
        logic [2:0] code;
        logic [2:0] sec;
        logic       off;
        logic       f1;
        logic       f3;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{3'b101, 3'd0, 1'b0, 1'b1, 1'b0},
        '{3'b100, 3'd1, 1'b0, 1'b1, 1'b1},
        '{3'b111, 3'd1, 1'b1, 1'b1, 1'b1},
        '{3'b110, 3'd2, 1'b0, 1'b1, 1'b0},
        '{3'b000, 3'd2, 1'b1, 1'b0, 1'b0},
        '{3'b010, 3'd3, 1'b0, 1'b0, 1'b1},
        '{3'b011, 3'd4, 1'b0, 1'b0, 1'b0},
        '{3'b001, 3'd5, 1'b0, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset(input logic rev);
        @(negedge clk);
        rst = 1'b1; dir_rev = rev; hall_in = 3'b101; pos = 0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    // n steps of s cycles each; fwd=1 increases the sector
    task automatic rotate(input int n, input bit fwd, input int s);
        for (int k = 0; k < n; k++) begin
            pos = fwd ? (pos + 1) % 6 : (pos + 5) % 6;
            hall_in = FWD[pos];
            wait_cyc(s);
        end
    endtask

    initial begin
        wait_cyc(3);
        chk("R1 mode in reset", int'(mode_sine), 0);
        chk("R1 off in reset", int'(outputs_off), 0);
        chk("R1 sector in reset", int'(sector), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mode after reset", int'(mode_sine), 0);
        wait_cyc(2);

        // table walk: R2 sectors, R3 invalid codes, R4 tachometer levels
        for (int i = 0; i < NV; i++) begin
            hall_in = VEC[i].code;
            wait_cyc(3);
            chk("R2 sector", int'(sector), int'(VEC[i].sec));
            chk("R3 outputs_off", int'(outputs_off), int'(VEC[i].off));
            chk("R4 fg1", int'(fg1), int'(VEC[i].f1));
            chk("R4 fg3", int'(fg3), int'(VEC[i].f3));
        end

        // R6: forward at speed, then R8 wrong-way step raising H2 (001 -> 011)
        do_reset(1'b0);
        chk("R6 block mode at start", int'(mode_sine), 0);
        rotate(17, 1'b1, 20);
        chk("R6 sine mode at speed", int'(mode_sine), 1);
        chk("R6 sector after 17 steps", int'(sector), 5);
        rotate(1, 1'b0, 5);
        chk("R8 mismatch with H2 rise drops mode", int'(mode_sine), 0);
        chk("R8 sector after back step", int'(sector), 4);

        // R6 again from sector 4, then R9 stall timeout
        rotate(17, 1'b1, 20);
        chk("R6 sine mode regained", int'(mode_sine), 1);
        wait_cyc(150);
        chk("R9 stall drops mode", int'(mode_sine), 0);

        // slow rotation never grants sine mode
        rotate(18, 1'b1, 60);
        chk("R9 slow rotation stays block", int'(mode_sine), 0);

        // R5 power-save while sine granted
        rotate(17, 1'b1, 20);
        chk("R6 sine before power-save", int'(mode_sine), 1);
        pwr_save = 1'b1;
        wait_cyc(3);
        chk("R5 fg1 high", int'(fg1), 1);
        chk("R5 fg3 high", int'(fg3), 1);
        chk("R5 mode dropped", int'(mode_sine), 0);
        pwr_save = 1'b0;

        // R7 reverse order, then R8 forward step under reverse command
        do_reset(1'b1);
        rotate(17, 1'b0, 20);
        chk("R7 reverse sine mode", int'(mode_sine), 1);
        chk("R7 reverse sector", int'(sector), 1);
        rotate(1, 1'b1, 5);
        chk("R8 forward step under reverse", int'(mode_sine), 0);

        // R7 forward rotation under reverse command never upgrades
        rotate(18, 1'b1, 20);
        chk("R7 wrong order stays block", int'(mode_sine), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #3_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule